// File: doc/BRIEF.md
# Keyboard and Display Register Unit

This unit gives a 16-bit processor four device registers at fixed bus addresses. Two of them belong to a keyboard input path and two to a character display output path. On every bus read the unit decodes the address. It returns either the word from the memory array or the contents of a device register, and the data is registered for the next cycle. Writes to a device address are kept away from memory, and writes to any other address are passed on as a memory write enable.

Each device has a status word. Bit 15 of that word is a ready flag that only the device rules move. Bit 14 is an interrupt enable that software may write. The keyboard side captures one character from a valid strobe and then refuses further characters until software reads the data word. The display side accepts one character while it is idle and pushes it to the sink as a one-cycle pulse. It then stays busy, dropping any further writes, until the sink reports completion. Each side raises an interrupt request while its ready and enable bits are both set.

Top module: `kbd_disp_mmio`

## Requirements
- R1: Address 0xFE00 selects the keyboard status word, 0xFE02 the keyboard data word, 0xFE04 the display status word and 0xFE06 the display data word. A read of any other address returns mem_rdata. mem_we equals bus_wr for non-device addresses and is 0 for the four device addresses.
- R2: bus_rdata is registered. The value selected in a cycle with bus_rd high appears after the next rising edge and is held until the next read.
- R3: A key_valid strobe while the keyboard ready bit is 0 stores key_char. After that, the keyboard data word reads {8'h00, key_char} and keyboard status bit 15 reads 1.
- R4: While the keyboard ready bit is 1, a strobe arriving without a keyboard data read is discarded. The stored character and the ready bit do not change.
- R5: A read of the keyboard data word clears the keyboard ready bit. If a strobe arrives in the same cycle, the read returns the old character, and the new character is stored with the ready bit left at 1.
- R6: A write to the display data word while display ready is 1 clears display ready. In the cycle after the write, disp_valid is 1 for exactly one cycle with disp_char equal to bus_wdata[7:0], and the display data word reads {8'h00, that byte}.
- R7: A write to the display data word while display ready is 0 is ignored. It produces no disp_valid pulse and does not change the stored character.
- R8: A disp_done pulse while display ready is 0 sets display ready back to 1.
- R9: A write to either status word changes only bit 14, taken from bus_wdata[14]. Bits 13..0 of both status words always read 0.
- R10: kbd_irq and disp_irq are registered. Each is 1 one cycle after its device's ready bit and enable bit are both 1, and 0 one cycle after either bit is 0.
- R11: After reset the keyboard status reads 0x0000, the display status reads 0x8000, and bus_rdata, disp_valid, kbd_irq and disp_irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| mem_rdata | input | 16 | Read data from the memory array |
| mem_we | output | 1 | Write enable forwarded to memory for non-device addresses |
| bus_rdata | output | 16 | Registered read data, from memory or a device register |
| key_valid | input | 1 | One-cycle strobe that a character is offered |
| key_char | input | 8 | Offered character code |
| disp_valid | output | 1 | One-cycle pulse that a character goes to the display |
| disp_char | output | 8 | Character sent to the display |
| disp_done | input | 1 | One-cycle pulse from the display sink that it can accept more |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
The two keyboard events that can fall in one cycle are a processor read of the data word and a fresh key strobe. The bench drives both on the same clock edge. It then judges the result in three places: the returned word must be the old character, the status word read next must still show ready, and the data word read after that must hold the new character. A matching collision on the display side, a busy write or a completion pulse against a pending character, is provoked inside a sweep of sink delays from zero to three cycles. In each case the bench checks that no second pulse leaves the unit.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  typedef enum logic [2:0] {
    SEL_MEM  = 3'd0,
    SEL_KSTAT = 3'd1,
    SEL_KDATA = 3'd2,
    SEL_DSTAT = 3'd3,
    SEL_DDATA = 3'd4
  } reg_sel_e;

  localparam int unsigned BUS_W  = 16;
  localparam int unsigned CHAR_W = 8;

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              is_dev
);

  always_comb begin
    if (addr == KSTAT_ADDR)      sel = SEL_KSTAT;
    else if (addr == KDATA_ADDR) sel = SEL_KDATA;
    else if (addr == DSTAT_ADDR) sel = SEL_DSTAT;
    else if (addr == DDATA_ADDR) sel = SEL_DDATA;
    else                         sel = SEL_MEM;
  end

  assign is_dev = (sel != SEL_MEM);

endmodule

// File: rtl/kbd_port.sv
module kbd_port #(
  parameter int unsigned CHAR_W  = 8,
  parameter bit          IRQ_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_char,
  input  logic              data_rd,
  input  logic              stat_wr,
  input  logic              ie_wdata,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] char_q,
  output logic              irq
);

  logic accept;
  assign accept = key_valid && (!ready || data_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready  <= 1'b0;
      char_q <= '0;
    end else if (accept) begin
      ready  <= 1'b1;
      char_q <= key_char;
    end else if (data_rd) begin
      ready  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ie <= 1'b0;
    else if (stat_wr) ie <= ie_wdata;
  end

  generate
    if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= ready && ie;
      end
    end else begin : g_irq_comb
      assign irq = ready && ie;
    end
  endgenerate

endmodule

// File: rtl/disp_port.sv
module disp_port #(
  parameter int unsigned CHAR_W  = 8,
  parameter bit          IRQ_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              stat_wr,
  input  logic              ie_wdata,
  input  logic              done,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] char_q,
  output logic              out_valid,
  output logic              irq
);

  logic take;
  assign take = data_wr && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b1;
      char_q    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) begin
        ready  <= 1'b0;
        char_q <= wchar;
      end else if (done) begin
        ready  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ie <= 1'b0;
    else if (stat_wr) ie <= ie_wdata;
  end

  generate
    if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= ready && ie;
      end
    end else begin : g_irq_comb
      assign irq = ready && ie;
    end
  endgenerate

endmodule

// File: rtl/kbd_disp_mmio.sv
module kbd_disp_mmio
  import mmio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CHAR_W  = 8,
  parameter bit          IRQ_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_char,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_done,
  output logic              kbd_irq,
  output logic              disp_irq
);

  localparam int unsigned RDY_BIT = DATA_W - 1;
  localparam int unsigned IE_BIT  = DATA_W - 2;

  reg_sel_e sel;
  logic     is_dev;

  mmio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .sel    (sel),
    .is_dev (is_dev)
  );

  assign mem_we = bus_wr && !is_dev;

  logic kdata_rd, kstat_wr, ddata_wr, dstat_wr;
  assign kdata_rd = bus_rd && (sel == SEL_KDATA);
  assign kstat_wr = bus_wr && (sel == SEL_KSTAT);
  assign ddata_wr = bus_wr && (sel == SEL_DDATA);
  assign dstat_wr = bus_wr && (sel == SEL_DSTAT);

  logic              kbd_ready, kbd_ie;
  logic [CHAR_W-1:0] kbd_char;
  logic              dsp_ready, dsp_ie;
  logic [CHAR_W-1:0] dsp_char;

  kbd_port #(.CHAR_W(CHAR_W), .IRQ_REG(IRQ_REG)) u_kbd (
    .clk       (clk),
    .rst       (rst),
    .key_valid (key_valid),
    .key_char  (key_char),
    .data_rd   (kdata_rd),
    .stat_wr   (kstat_wr),
    .ie_wdata  (bus_wdata[IE_BIT]),
    .ready     (kbd_ready),
    .ie        (kbd_ie),
    .char_q    (kbd_char),
    .irq       (kbd_irq)
  );

  disp_port #(.CHAR_W(CHAR_W), .IRQ_REG(IRQ_REG)) u_dsp (
    .clk       (clk),
    .rst       (rst),
    .data_wr   (ddata_wr),
    .wchar     (bus_wdata[CHAR_W-1:0]),
    .stat_wr   (dstat_wr),
    .ie_wdata  (bus_wdata[IE_BIT]),
    .done      (disp_done),
    .ready     (dsp_ready),
    .ie        (dsp_ie),
    .char_q    (dsp_char),
    .out_valid (disp_valid),
    .irq       (disp_irq)
  );

  assign disp_char = dsp_char;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DATA_W-1], bus_wdata[IE_BIT-1:CHAR_W]};

  logic [DATA_W-1:0] kstat_word, dstat_word, kdata_word, ddata_word, rd_next;

  always_comb begin
    kstat_word          = '0;
    kstat_word[RDY_BIT] = kbd_ready;
    kstat_word[IE_BIT]  = kbd_ie;
    dstat_word          = '0;
    dstat_word[RDY_BIT] = dsp_ready;
    dstat_word[IE_BIT]  = dsp_ie;
    kdata_word          = '0;
    kdata_word[CHAR_W-1:0] = kbd_char;
    ddata_word          = '0;
    ddata_word[CHAR_W-1:0] = dsp_char;
  end

  always_comb begin
    unique case (sel)
      SEL_KSTAT: rd_next = kstat_word;
      SEL_KDATA: rd_next = kdata_word;
      SEL_DSTAT: rd_next = dstat_word;
      SEL_DDATA: rd_next = ddata_word;
      default:   rd_next = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/kbd_disp_mmio_chk.sv
module kbd_disp_mmio_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              mem_we,
  input logic              key_valid,
  input logic              disp_valid,
  input logic              kbd_irq,
  input logic              kbd_ready,
  input logic              kbd_ie,
  input logic [CHAR_W-1:0] kbd_char,
  input logic              dsp_ready
);

  logic kd_rd, dd_wr;
  assign kd_rd = bus_rd && (bus_addr == 16'hFE02);
  assign dd_wr = bus_wr && (bus_addr == 16'hFE06);

  // R1
  mem_we_src_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> bus_wr);

  // R4
  kbd_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (kbd_ready && key_valid && !kd_rd) |=> ($stable(kbd_char) && kbd_ready));

  // R5
  kbd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (kd_rd && !key_valid) |=> !kbd_ready);

  // R5
  kbd_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (kd_rd && key_valid) |=> kbd_ready);

  // R7
  disp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!dsp_ready && dd_wr) |=> !disp_valid);

  // R6
  disp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid);

  // R10
  kbd_irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    (kbd_ready && kbd_ie) |=> kbd_irq);

  // R10
  kbd_irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(kbd_ready && kbd_ie) |=> !kbd_irq);

endmodule

bind kbd_disp_mmio kbd_disp_mmio_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .mem_we     (mem_we),
  .key_valid  (key_valid),
  .disp_valid (disp_valid),
  .kbd_irq    (kbd_irq),
  .kbd_ready  (kbd_ready),
  .kbd_ie     (kbd_ie),
  .kbd_char   (kbd_char),
  .dsp_ready  (dsp_ready)
);

// File: tb/kbd_disp_mmio_test.sv
`timescale 1ns/100ps
module kbd_disp_mmio_test;

  localparam logic [15:0] A_KS = 16'hFE00;
  localparam logic [15:0] A_KD = 16'hFE02;
  localparam logic [15:0] A_DS = 16'hFE04;
  localparam logic [15:0] A_DD = 16'hFE06;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata, mem_rdata;
  logic        mem_we;
  logic [15:0] bus_rdata;
  logic        key_valid;
  logic [7:0]  key_char;
  logic        disp_valid;
  logic [7:0]  disp_char;
  logic        disp_done;
  logic        kbd_irq, disp_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  kbd_disp_mmio uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .bus_rdata(bus_rdata), .key_valid(key_valid), .key_char(key_char),
    .disp_valid(disp_valid), .disp_char(disp_char), .disp_done(disp_done),
    .kbd_irq(kbd_irq), .disp_irq(disp_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] m, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; mem_rdata = m;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk);
    key_valid = 1'b1; key_char = c;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    disp_done = 1'b1;
    @(negedge clk);
    disp_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst = 1'b1; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    mem_rdata = '0; key_valid = 0; key_char = '0; disp_done = 0;
    idle(3);
    rst = 1'b0;

    // R11 reset state
    chk("R11 rdata", bus_rdata, 16'h0);
    chk("R11 irq", {14'b0, kbd_irq, disp_irq}, 16'h0);
    chk("R11 disp_valid", {15'b0, disp_valid}, 16'h0);
    rd(A_KS, 16'h1111, d); chk("R11 kstat", d, 16'h0000);
    rd(A_DS, 16'h2222, d); chk("R11 dstat", d, 16'h8000);

    // R1 memory steering and write enable
    rd(16'h3000, 16'hBEEF, d); chk("R1 mem read", d, 16'hBEEF);
    rd(16'hFE08, 16'h1234, d); chk("R1 near addr", d, 16'h1234);
    rd(16'hFE01, 16'h5A5A, d); chk("R1 odd addr", d, 16'h5A5A);
    @(negedge clk); bus_addr = 16'h4000; bus_wr = 1'b1; bus_wdata = 16'h0;
    #1 chk("R1 mem_we mem", {15'b0, mem_we}, 16'h1);
    @(negedge clk); bus_addr = A_KD;
    #1 chk("R1 mem_we dev", {15'b0, mem_we}, 16'h0);
    @(negedge clk); bus_wr = 1'b0;
    // R2 hold between reads
    idle(2); chk("R2 hold", bus_rdata, 16'h5A5A);

    // R3 / R5 sweep over all character codes
    for (int c = 0; c < 256; c++) begin
      key(8'(c));
      rd(A_KS, 16'h0, d); chk("R3 ready", d, 16'h8000);
      rd(A_KD, 16'h0, d); chk("R3 data", d, {8'h00, 8'(c)});
      rd(A_KS, 16'h0, d); chk("R5 cleared", d, 16'h0000);
    end

    // R4 lockout
    key(8'h41); key(8'h42);
    rd(A_KD, 16'h0, d); chk("R4 lockout", d, 16'h0041);

    // R5 read and strobe in same cycle
    key(8'h55);
    @(negedge clk);
    bus_addr = A_KD; bus_rd = 1'b1; key_valid = 1'b1; key_char = 8'h66;
    @(negedge clk);
    bus_rd = 1'b0; key_valid = 1'b0;
    chk("R5 old char", bus_rdata, 16'h0055);
    rd(A_KS, 16'h0, d); chk("R5 still ready", d, 16'h8000);
    rd(A_KD, 16'h0, d); chk("R5 new char", d, 16'h0066);

    // R9 status writes
    wr(A_KS, 16'hFFFF);
    rd(A_KS, 16'h0, d); chk("R9 kstat ie only", d, 16'h4000);
    idle(1); chk("R10 kbd irq low", {15'b0, kbd_irq}, 16'h0);
    // R10 keyboard irq
    key(8'h31); idle(1);
    chk("R10 kbd irq high", {15'b0, kbd_irq}, 16'h1);
    rd(A_KD, 16'h0, d); idle(1);
    chk("R10 kbd irq drop", {15'b0, kbd_irq}, 16'h0);
    wr(A_KS, 16'h0000);
    rd(A_KS, 16'h0, d); chk("R9 kstat clear", d, 16'h0000);
    wr(A_DS, 16'h3FFF);
    rd(A_DS, 16'h0, d); chk("R9 dstat ready kept", d, 16'h8000);

    // R6 / R7 / R8 display path
    wr(A_DD, 16'h1241);
    chk("R6 pulse", {7'b0, disp_valid, disp_char}, 16'h0141);
    idle(1); chk("R6 one cycle", {15'b0, disp_valid}, 16'h0);
    rd(A_DS, 16'h0, d); chk("R6 busy", d, 16'h0000);
    wr(A_DD, 16'h0077);
    chk("R7 no pulse", {15'b0, disp_valid}, 16'h0);
    rd(A_DD, 16'h0, d); chk("R7 kept", d, 16'h0041);
    done_pulse();
    rd(A_DS, 16'h0, d); chk("R8 ready", d, 16'h8000);

    // R10 display irq
    wr(A_DS, 16'h4000); idle(1);
    chk("R10 disp irq high", {15'b0, disp_irq}, 16'h1);
    wr(A_DD, 16'h0020); idle(1);
    chk("R10 disp irq drop", {15'b0, disp_irq}, 16'h0);
    done_pulse(); idle(1);
    chk("R10 disp irq back", {15'b0, disp_irq}, 16'h1);
    wr(A_DS, 16'h0000);

    // R6 / R7 / R8 sweep over sink delays
    for (int c = 0; c < 32; c++) begin
      wr(A_DD, {8'hA5 ^ 8'(c), 8'(c + 64)});
      chk("R6 sweep pulse", {7'b0, disp_valid, disp_char}, {7'b0, 1'b1, 8'(c + 64)});
      for (int k = 0; k < c % 4; k++) begin
        wr(A_DD, 16'h00FF);
        chk("R7 sweep drop", {15'b0, disp_valid}, 16'h0);
      end
      done_pulse();
      rd(A_DS, 16'h0, d); chk("R8 sweep ready", d, 16'h8000);
      rd(A_DD, 16'h0, d); chk("R7 sweep data", d, {8'h00, 8'(c + 64)});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule